// File: doc/BRIEF.md
# ACPI Embedded Controller Mailbox

This block is a byte-wide mailbox that links a host, which reaches it through I/O-port reads and writes, to a local microcontroller, which reaches it through a memory-mapped bus. It has `NUM_CH` independent channels, two by default. Each channel holds four bytes: the inbound data byte and the inbound command byte, which share one latch, the outbound byte, and a status byte built from three handshake flags. The flags are input-full (IBF), output-full (OBF) and command/data (C/D).

The host has two I/O ports per channel. The data port accepts data writes and returns the outbound byte on reads. The command port accepts command writes and returns the status byte on reads. Both host port addresses of every channel come from configuration inputs, so firmware can move them. On the local side, each channel has a data location and a status location at fixed offsets from a parameter base. The data location is at base + 2·n and the status location is at base + 2·n + 1.

Each channel drives IBF as a level interrupt toward the local processor and OBF as a level flag toward the host. Read data on both sides is registered. It appears in the cycle after the read strobe and holds until the next read.

Top module: `ec_mailbox_top`

## Requirements
- R1: After reset, all flags are 0, `ec_irq`, `host_obf`, `host_rdata` and `loc_rdata` are 0.
- R2: A host write to a channel's data port latches the byte, sets IBF and clears C/D, visible one cycle after the write.
- R3: A host write to a channel's command port latches the byte, sets IBF and sets C/D.
- R4: A host read of a data port returns that channel's outbound byte on `host_rdata` the next cycle and clears OBF.
- R5: A host read of a command port returns the status byte. The layout is bit 0 = OBF, bit 1 = IBF, bit 3 = C/D, and all other bits are 0. The read does not change any flag.
- R6: A local read of a channel's data location (base + 2·n) returns the latched host byte the next cycle and clears IBF.
- R7: A local write to a data location loads the outbound byte and sets OBF.
- R8: A local read of a status location (base + 2·n + 1) returns the same status byte as in R5. Local writes to a status location change nothing.
- R9: A host write while IBF is already 1 replaces the latched byte, and IBF stays 1.
- R10: When both sides act on one channel in the same cycle, the host's update wins. A host write together with a local data read leaves IBF at 1. A host data read together with a local data write leaves OBF at 0.
- R11: Channels are independent. Host accesses decode only against the configured port addresses. An access to any other address changes nothing, and a read of it returns 0.
- R12: `ec_irq[n]` equals IBF of channel n, and `host_obf[n]` equals OBF of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_port | input | NUM_CH*HAW | Host data-port address per channel, channel n in slice n |
| cfg_cmd_port | input | NUM_CH*HAW | Host command/status-port address per channel |
| host_addr | input | HAW | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| loc_addr | input | LAW | Local bus address |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Local read byte, registered |
| ec_irq | output | NUM_CH | IBF level per channel, toward the local processor |
| host_obf | output | NUM_CH | OBF level per channel, toward the host |

## Verification
A wrong flag shows up on `ec_irq` or `host_obf` in the cycle right after the access that caused it. The same fault also appears one cycle after any status read from either side, because the status byte is assembled from those same flags. A corrupted latched byte only becomes visible when the opposite side reads the data location or data port. For that reason, every byte value is sent through each channel and read back at once. Decode faults appear as a flag change on the wrong channel, or as a non-zero read from an address that no channel owns.

// File: rtl/ec_mbx_pkg.sv
package ec_mbx_pkg;
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CD  = 3;

  function automatic logic [7:0] pack_status(input logic obf, input logic ibf, input logic cd);
    logic [7:0] s;
    s = 8'h00;
    s[ST_OBF] = obf;
    s[ST_IBF] = ibf;
    s[ST_CD]  = cd;
    return s;
  endfunction
endpackage

// File: rtl/ec_addr_match.sv
module ec_addr_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] port_a,
  input  logic [AW-1:0] port_b,
  output logic          hit_a,
  output logic          hit_b
);
  assign hit_a = (addr == port_a);
  assign hit_b = (addr == port_b);
endmodule

// File: rtl/ec_chan.sv
module ec_chan
  import ec_mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       h_data_wr,
  input  logic       h_cmd_wr,
  input  logic       h_data_rd,
  input  logic [7:0] h_wbyte,
  input  logic       l_data_rd,
  input  logic       l_data_wr,
  input  logic [7:0] l_wbyte,
  output logic [7:0] in_byte,
  output logic [7:0] out_byte,
  output logic [7:0] status,
  output logic       ibf,
  output logic       obf
);
  logic cd;
  logic h_any_wr;

  assign h_any_wr = h_data_wr | h_cmd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte  <= 8'h00;
      out_byte <= 8'h00;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      cd       <= 1'b0;
    end else begin
      if (h_any_wr) begin
        in_byte <= h_wbyte;
        ibf     <= 1'b1;
        cd      <= h_cmd_wr;
      end else if (l_data_rd) begin
        ibf <= 1'b0;
      end
      if (l_data_wr) out_byte <= l_wbyte;
      if (h_data_rd)      obf <= 1'b0;
      else if (l_data_wr) obf <= 1'b1;
    end
  end

  assign status = pack_status(obf, ibf, cd);

  a_r3_cmd_write: assert property (@(posedge clk) disable iff (rst)
    h_cmd_wr |=> ibf && cd && in_byte == $past(h_wbyte));
  a_r2_data_write: assert property (@(posedge clk) disable iff (rst)
    (h_data_wr && !h_cmd_wr) |=> ibf && !cd && in_byte == $past(h_wbyte));
  a_r4_host_rd_clears: assert property (@(posedge clk) disable iff (rst)
    h_data_rd |=> !obf);
  a_r6_loc_rd_clears: assert property (@(posedge clk) disable iff (rst)
    (l_data_rd && !h_any_wr) |=> !ibf);
  a_r7_loc_wr_sets: assert property (@(posedge clk) disable iff (rst)
    (l_data_wr && !h_data_rd) |=> obf && out_byte == $past(l_wbyte));
  a_r10_host_wins: assert property (@(posedge clk) disable iff (rst)
    (h_any_wr && l_data_rd) |=> ibf);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(h_any_wr || h_data_rd || l_data_rd || l_data_wr) |=> $stable(status) && $stable(in_byte) && $stable(out_byte));
endmodule

// File: rtl/ec_mailbox_top.sv
module ec_mailbox_top #(
  parameter int NUM_CH = 2,
  parameter int HAW = 16,
  parameter int LAW = 16,
  parameter logic [LAW-1:0] LOC_BASE = 16'h7F50
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH*HAW-1:0] cfg_data_port,
  input  logic [NUM_CH*HAW-1:0] cfg_cmd_port,
  input  logic [HAW-1:0]        host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  input  logic [LAW-1:0]        loc_addr,
  input  logic                  loc_wr,
  input  logic                  loc_rd,
  input  logic [7:0]            loc_wdata,
  output logic [7:0]            loc_rdata,
  output logic [NUM_CH-1:0]     ec_irq,
  output logic [NUM_CH-1:0]     host_obf
);
  logic [NUM_CH-1:0] h_hit_d, h_hit_c, l_hit_d, l_hit_s;
  logic [7:0] ch_in [NUM_CH];
  logic [7:0] ch_out [NUM_CH];
  logic [7:0] ch_st [NUM_CH];
  logic [NUM_CH-1:0] ch_ibf, ch_obf;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [LAW-1:0] LOC_D = LAW'(LOC_BASE + LAW'(2 * c));
    localparam logic [LAW-1:0] LOC_S = LAW'(LOC_BASE + LAW'(2 * c + 1));

    ec_addr_match #(.AW(HAW)) u_hdec (
      .addr(host_addr),
      .port_a(cfg_data_port[c*HAW +: HAW]),
      .port_b(cfg_cmd_port[c*HAW +: HAW]),
      .hit_a(h_hit_d[c]),
      .hit_b(h_hit_c[c])
    );

    ec_addr_match #(.AW(LAW)) u_ldec (
      .addr(loc_addr),
      .port_a(LOC_D),
      .port_b(LOC_S),
      .hit_a(l_hit_d[c]),
      .hit_b(l_hit_s[c])
    );

    ec_chan u_chan (
      .clk(clk),
      .rst(rst),
      .h_data_wr(host_wr & h_hit_d[c]),
      .h_cmd_wr(host_wr & h_hit_c[c]),
      .h_data_rd(host_rd & h_hit_d[c]),
      .h_wbyte(host_wdata),
      .l_data_rd(loc_rd & l_hit_d[c]),
      .l_data_wr(loc_wr & l_hit_d[c]),
      .l_wbyte(loc_wdata),
      .in_byte(ch_in[c]),
      .out_byte(ch_out[c]),
      .status(ch_st[c]),
      .ibf(ch_ibf[c]),
      .obf(ch_obf[c])
    );
  end

  logic [7:0] h_sel, l_sel;

  always_comb begin
    h_sel = 8'h00;
    l_sel = 8'h00;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (h_hit_d[c])      h_sel = ch_out[c];
      else if (h_hit_c[c]) h_sel = ch_st[c];
      if (l_hit_d[c])      l_sel = ch_in[c];
      else if (l_hit_s[c]) l_sel = ch_st[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= 8'h00;
      loc_rdata  <= 8'h00;
    end else begin
      if (host_rd) host_rdata <= h_sel;
      if (loc_rd)  loc_rdata  <= l_sel;
    end
  end

  assign ec_irq   = ch_ibf;
  assign host_obf = ch_obf;

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> ec_irq == '0 && host_obf == '0 && host_rdata == 8'h00);
  a_r5_rd_no_flag_change: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && !loc_rd && !loc_wr && !(|h_hit_d)) |=> $stable(ec_irq) && $stable(host_obf));
  a_r11_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !(|h_hit_d) && !(|h_hit_c)) |=> host_rdata == 8'h00);
endmodule

// File: tb/ec_mailbox_top_tb.sv
`timescale 1ns/1ps
module ec_mailbox_top_tb;
  localparam int NCH = 2;
  logic clk = 0;
  logic rst;
  logic [31:0] cfg_d, cfg_c;
  logic [15:0] h_addr, l_addr;
  logic h_wr, h_rd, l_wr, l_rd;
  logic [7:0] h_wd, l_wd, h_rdata, l_rdata;
  logic [NCH-1:0] irq, hobf;
  int checks = 0, fails = 0;
  logic m_ibf[NCH], m_obf[NCH], m_cd[NCH];

  always #2 clk = ~clk;

  ec_mailbox_top u_dut (
    .clk(clk), .rst(rst), .cfg_data_port(cfg_d), .cfg_cmd_port(cfg_c),
    .host_addr(h_addr), .host_wr(h_wr), .host_rd(h_rd), .host_wdata(h_wd), .host_rdata(h_rdata),
    .loc_addr(l_addr), .loc_wr(l_wr), .loc_rd(l_rd), .loc_wdata(l_wd), .loc_rdata(l_rdata),
    .ec_irq(irq), .host_obf(hobf)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input int c);
    return {4'b0, m_cd[c], 1'b0, m_ibf[c], m_obf[c]};
  endfunction

  function automatic logic [15:0] hd(input int c); return cfg_d[c*16 +: 16]; endfunction
  function automatic logic [15:0] hc(input int c); return cfg_c[c*16 +: 16]; endfunction
  function automatic logic [15:0] ld(input int c); return 16'h7F50 + 16'(2*c); endfunction

  task automatic cyc(input logic [15:0] ha, input logic hw, input logic hr, input logic [7:0] hwd,
                     input logic [15:0] la, input logic lw, input logic lr, input logic [7:0] lwd);
    @(negedge clk);
    h_addr = ha; h_wr = hw; h_rd = hr; h_wd = hwd;
    l_addr = la; l_wr = lw; l_rd = lr; l_wd = lwd;
    @(negedge clk);
    h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
  endtask

  task automatic flags(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk({req, " irq"}, 8'(irq[c]), 8'(m_ibf[c]));
      chk({req, " obf"}, 8'(hobf[c]), 8'(m_obf[c]));
    end
  endtask

  task automatic status_both(input string req, input int c);
    cyc(hc(c), 0, 1, 0, 16'h0, 0, 0, 0);
    chk({req, " host status"}, h_rdata, st(c));
    cyc(16'h0, 0, 0, 0, ld(c) + 16'd1, 0, 1, 0);
    chk({req, " local status"}, l_rdata, st(c));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; cfg_d = {16'h0068, 16'h0062}; cfg_c = {16'h006C, 16'h0066};
    h_addr = 0; l_addr = 0; h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0; h_wd = 0; l_wd = 0;
    for (int c = 0; c < NCH; c++) begin m_ibf[c] = 0; m_obf[c] = 0; m_cd[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", 8'(irq), 0); chk("R1 obf", 8'(hobf), 0);
    chk("R1 hrd", h_rdata, 0); chk("R1 lrd", l_rdata, 0);

    for (int c = 0; c < NCH; c++) begin
      for (int v = 0; v < 256; v++) begin
        // R2 data write, R6 local read
        cyc(hd(c), 1, 0, 8'(v), 16'h0, 0, 0, 0);
        m_ibf[c] = 1; m_cd[c] = 0;
        flags("R2 R12");
        cyc(16'h0, 0, 0, 0, ld(c), 0, 1, 0);
        chk("R6 byte", l_rdata, 8'(v));
        m_ibf[c] = 0;
        flags("R6");
        // R7 local write, R4 host read
        cyc(16'h0, 0, 0, 0, ld(c), 1, 0, 8'(255 - v));
        m_obf[c] = 1;
        flags("R7 R12");
        cyc(hd(c), 0, 1, 0, 16'h0, 0, 0, 0);
        chk("R4 byte", h_rdata, 8'(255 - v));
        m_obf[c] = 0;
        flags("R4");
      end
      // R3 command write and status layout R5/R8
      cyc(hc(c), 1, 0, 8'hA5, 16'h0, 0, 0, 0);
      m_ibf[c] = 1; m_cd[c] = 1;
      flags("R3");
      status_both("R3 R5 R8", c);
      flags("R5");
      cyc(16'h0, 0, 0, 0, ld(c), 0, 1, 0);
      chk("R3 byte", l_rdata, 8'hA5); m_ibf[c] = 0;
      // R8 write to status location ignored
      cyc(16'h0, 0, 0, 0, ld(c) + 16'd1, 1, 0, 8'hFF);
      flags("R8 ignore");
      status_both("R8 ignore", c);
      // R9 overwrite
      cyc(hd(c), 1, 0, 8'h11, 16'h0, 0, 0, 0);
      cyc(hc(c), 1, 0, 8'h22, 16'h0, 0, 0, 0);
      m_ibf[c] = 1; m_cd[c] = 1;
      flags("R9");
      cyc(16'h0, 0, 0, 0, ld(c), 0, 1, 0);
      chk("R9 byte", l_rdata, 8'h22); m_ibf[c] = 0;
      // R10 host write vs local read
      cyc(hd(c), 1, 0, 8'h33, ld(c), 0, 1, 0);
      m_ibf[c] = 1; m_cd[c] = 0;
      flags("R10 ibf");
      cyc(16'h0, 0, 0, 0, ld(c), 1, 0, 8'h44);
      m_obf[c] = 1;
      // R10 host read vs local write
      cyc(hd(c), 0, 1, 0, ld(c), 1, 0, 8'h55);
      chk("R10 old byte", h_rdata, 8'h44);
      m_obf[c] = 0;
      flags("R10 obf");
      status_both("R10", c);
      cyc(16'h0, 0, 0, 0, ld(c), 0, 1, 0);
      chk("R10 byte", l_rdata, 8'h33); m_ibf[c] = 0;
      flags("R11 independence");
    end

    // R11 reprogrammed ports: old address ignored, new one decoded
    cfg_d[31:16] = 16'h0300; cfg_c[31:16] = 16'h0304;
    cyc(16'h0068, 1, 0, 8'h77, 16'h0, 0, 0, 0);
    flags("R11 old port write");
    cyc(16'h006C, 0, 1, 0, 16'h0, 0, 0, 0);
    chk("R11 old port read", h_rdata, 8'h00);
    cyc(16'h0304, 1, 0, 8'h66, 16'h0, 0, 0, 0);
    m_ibf[1] = 1; m_cd[1] = 1;
    flags("R11 new port");
    status_both("R11 new port", 1);
    status_both("R11 ch0 untouched", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule